// File: doc/BRIEF.md
# Synthesizable Assertion Trip Recorder

This block watches a vector of assertion stop conditions coming out of a target model that advances one target cycle per accepted timing token. Each condition bit is already qualified by its own enable. The block checks the bits only on a cycle where it accepts a token. When at least one bit is set on such a cycle, it latches two values. The first is a numeric code for the assertion that fired, and software maps this code back to an error message. The second is the exact target cycle at which the assertion fired. The block then raises its halt flag and stops accepting tokens, so target time freezes at the failing cycle. This replaces ending a run with a simulator fatal call.

Software reads the recorded code and cycle stamp while the halt is held. A single clear pulse wipes the record and lets target time run again. The target-cycle counter is never reset by a clear, so later trips carry absolute stamps.

Top module: `trip_recorder`

## Requirements
- R1: While reset is high and on the first cycle after it, halt_o and trip_valid_o are 0, trip_id_o and trip_cycle_o are 0, and tok_ready_o is 1.
- R2: The target-cycle counter is 64 bits wide and counts only accepted tokens. A token is accepted when tok_valid_i and tok_ready_o are both 1. trip_cycle_o equals the number of tokens accepted since reset before the token on which the trip occurred.
- R3: cond_i is ignored on cycles with no accepted token. A set condition bit with tok_valid_i low never causes a trip.
- R4: If cond_i is nonzero on an accepted token, then after that clock edge halt_o and trip_valid_o are 1 and tok_ready_o is 0.
- R5: trip_id_o is the bit index (0 to N_COND-1) of the lowest-numbered set bit of cond_i on the tripping token.
- R6: While halted, tok_ready_o is 0 and offered tokens are not accepted. Blocked tokens do not advance the counter, which is visible in the stamp of the next trip.
- R7: While halted and with no clear, trip_id_o and trip_cycle_o stay unchanged whatever cond_i and tok_valid_i do.
- R8: After a cycle with clear_i high, halt_o and trip_valid_o are 0, trip_id_o and trip_cycle_o are 0, and the counter keeps its value. A trip on the same cycle as a clear takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | N_COND | Enabled assertion stop conditions, one bit per assertion |
| tok_valid_i | input | 1 | A target-cycle-advance token is offered |
| tok_ready_o | output | 1 | Token can be accepted (low while halted) |
| clear_i | input | 1 | Clear pulse: drop the record and release halt |
| halt_o | output | 1 | Target advancement halted by a trip |
| trip_valid_o | output | 1 | Record holds a captured trip |
| trip_id_o | output | ID_W | Code of the reported assertion |
| trip_cycle_o | output | CYC_W | Target cycle of the trip |

## Verification
Every result is due one clock edge after its stimulus. This covers the trip record and halt set by an accepted token, the counter step, and the release by a clear. tok_ready_o follows the halt register, so it changes on that same edge. The bench applies each input at a falling edge and lets exactly one rising edge pass. It updates its reference model at that rising edge and compares all outputs at the next falling edge. A result is therefore never read before the register that carries it has been loaded.

// File: rtl/trip_pkg.sv
package trip_pkg;
  localparam int DEF_N_COND = 16;
  localparam int DEF_CYC_W  = 64;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HALT = 1'b1
  } trip_state_e;
endpackage

// File: rtl/trip_prio_enc.sv
module trip_prio_enc #(
  parameter int N_COND = 16,
  localparam int ID_W  = $clog2(N_COND)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_COND-1:0] cond,
  output logic              hit,
  output logic [ID_W-1:0]   hit_id
);
  always_comb begin
    hit    = |cond;
    hit_id = '0;
    for (int i = N_COND - 1; i >= 0; i--) begin
      if (cond[i]) hit_id = ID_W'(i);
    end
  end

  logic lowest_ok;
  always_comb begin
    lowest_ok = 1'b1;
    if (hit) begin
      if (!cond[hit_id]) lowest_ok = 1'b0;
      for (int j = 0; j < N_COND; j++) begin
        if (j < int'(hit_id) && cond[j]) lowest_ok = 1'b0;
      end
    end
  end

  assert_lowest_wins_R5: assert property (@(posedge clk) disable iff (rst) lowest_ok)
    else $error("encoder did not pick lowest set condition");
endmodule

// File: rtl/trip_cycle_ctr.sv
module trip_cycle_ctr #(
  parameter int CYC_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [CYC_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (adv) count <= count + 1'b1;
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    adv |=> count == $past(count) + 1'b1)
    else $error("counter did not step on accepted token");
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(count))
    else $error("counter moved without accepted token");
endmodule

// File: rtl/trip_capture.sv
module trip_capture
  import trip_pkg::*;
#(
  parameter int N_COND = 16,
  parameter int CYC_W  = 64,
  localparam int ID_W  = $clog2(N_COND)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             hit,
  input  logic [ID_W-1:0]  hit_id,
  input  logic [CYC_W-1:0] count,
  input  logic             clear,
  output trip_state_e      state,
  output logic [ID_W-1:0]  id_q,
  output logic [CYC_W-1:0] cyc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_RUN;
      id_q  <= '0;
      cyc_q <= '0;
    end else if (adv && hit) begin
      state <= ST_HALT;
      id_q  <= hit_id;
      cyc_q <= count;
    end else if (clear) begin
      state <= ST_RUN;
      id_q  <= '0;
      cyc_q <= '0;
    end
  end

  assert_trip_halts_R4: assert property (@(posedge clk) disable iff (rst)
    (adv && hit) |=> state == ST_HALT)
    else $error("trip did not halt");
  assert_no_trip_without_token_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && !adv) |=> state == ST_RUN)
    else $error("halt without accepted token");
  assert_hold_while_halted_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HALT && !clear) |=> ($stable(id_q) && $stable(cyc_q) && state == ST_HALT))
    else $error("record changed while halted");
  assert_clear_releases_R8: assert property (@(posedge clk) disable iff (rst)
    (clear && !(adv && hit)) |=> (state == ST_RUN && id_q == '0 && cyc_q == '0))
    else $error("clear did not release");
endmodule

// File: rtl/trip_recorder.sv
module trip_recorder
  import trip_pkg::*;
#(
  parameter int N_COND = DEF_N_COND,
  parameter int CYC_W  = DEF_CYC_W,
  localparam int ID_W  = $clog2(N_COND)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_COND-1:0] cond_i,
  input  logic              tok_valid_i,
  output logic              tok_ready_o,
  input  logic              clear_i,
  output logic              halt_o,
  output logic              trip_valid_o,
  output logic [ID_W-1:0]   trip_id_o,
  output logic [CYC_W-1:0]  trip_cycle_o
);
  trip_state_e      state;
  logic             accept;
  logic             hit;
  logic [ID_W-1:0]  hit_id;
  logic [CYC_W-1:0] count;

  assign tok_ready_o  = (state == ST_RUN);
  assign accept       = tok_valid_i && tok_ready_o;
  assign halt_o       = (state == ST_HALT);
  assign trip_valid_o = (state == ST_HALT);

  trip_prio_enc #(.N_COND(N_COND)) u_enc (
    .clk(clk), .rst(rst), .cond(cond_i), .hit(hit), .hit_id(hit_id)
  );

  trip_cycle_ctr #(.CYC_W(CYC_W)) u_ctr (
    .clk(clk), .rst(rst), .adv(accept), .count(count)
  );

  trip_capture #(.N_COND(N_COND), .CYC_W(CYC_W)) u_cap (
    .clk(clk), .rst(rst), .adv(accept), .hit(hit), .hit_id(hit_id),
    .count(count), .clear(clear_i), .state(state),
    .id_q(trip_id_o), .cyc_q(trip_cycle_o)
  );

  assert_blocked_count_R6: assert property (@(posedge clk) disable iff (rst)
    (halt_o && tok_valid_i) |=> $stable(count))
    else $error("blocked token advanced target time");
endmodule

// File: tb/trip_recorder_bench.sv
module trip_recorder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 16;
  localparam int CW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NC-1:0] cond = '0;
  logic          tok_valid = 1'b0;
  logic          clear = 1'b0;
  logic          tok_ready, halt, tvalid;
  logic [3:0]    tid;
  logic [CW-1:0] tcyc;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic          m_halt = 1'b0;
  logic [3:0]    m_id = '0;
  logic [CW-1:0] m_cyc = '0;
  logic [CW-1:0] m_count = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trip_recorder #(.N_COND(NC), .CYC_W(CW)) u_trip_recorder (
    .clk(clk), .rst(rst), .cond_i(cond), .tok_valid_i(tok_valid),
    .tok_ready_o(tok_ready), .clear_i(clear), .halt_o(halt),
    .trip_valid_o(tvalid), .trip_id_o(tid), .trip_cycle_o(tcyc)
  );

  function automatic logic [3:0] first_bit(input logic [NC-1:0] c);
    for (int k = 0; k < NC; k++) if (c[k]) return 4'(k);
    return 4'd0;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "tok_ready", CW'(tok_ready), CW'(!m_halt));
    chk(tag, "halt", CW'(halt), CW'(m_halt));
    chk(tag, "trip_valid", CW'(tvalid), CW'(m_halt));
    chk(tag, "trip_id", CW'(tid), CW'(m_id));
    chk(tag, "trip_cycle", tcyc, m_cyc);
  endtask

  task automatic step(input logic tv, input logic [NC-1:0] c,
                      input logic clr, input string tag);
    logic acc;
    tok_valid = tv; cond = c; clear = clr;
    @(posedge clk);
    acc = tv && !m_halt;
    if (acc && c != '0) begin
      m_halt = 1'b1; m_id = first_bit(c); m_cyc = m_count;
    end else if (clr) begin
      m_halt = 1'b0; m_id = '0; m_cyc = '0;
    end
    if (acc) m_count = m_count + 1'b1;
    @(negedge clk);
    tok_valid = 1'b0; cond = '0; clear = 1'b0;
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7391));
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1");
    rst = 1'b0;
    step(1'b0, '0, 1'b0, "R1");
    // five clean tokens, then a condition with no token offered
    for (int i = 0; i < 5; i++) step(1'b1, '0, 1'b0, "R2");
    step(1'b0, 16'hFFFF, 1'b0, "R3");
    step(1'b0, 16'h0001, 1'b0, "R3");
    // trip: bits 4,5,9,11 set -> id 4, stamp 5
    step(1'b1, 16'h0A30, 1'b0, "R4/R5");
    chk("R5", "lowest id", CW'(tid), 64'd4);
    chk("R2", "stamp", tcyc, 64'd5);
    // halted: tokens and conditions must not disturb anything
    for (int i = 0; i < 4; i++) step(1'b1, 16'h0001, 1'b0, "R6/R7");
    chk("R7", "held id", CW'(tid), 64'd4);
    step(1'b0, '0, 1'b1, "R8");
    // next token trips at once: stamp 6 proves blocked tokens were not counted
    step(1'b1, 16'h8000, 1'b0, "R6");
    chk("R6", "stamp after block", tcyc, 64'd6);
    chk("R5", "top id", CW'(tid), 64'd15);
    step(1'b0, '0, 1'b1, "R8");
    // trip coinciding with clear: trip wins
    step(1'b1, 16'h0006, 1'b1, "R8");
    chk("R8", "trip over clear", CW'(tvalid), 64'd1);
    step(1'b0, '0, 1'b1, "R8");
    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic tv, clr;
      logic [NC-1:0] c;
      tv  = ($urandom % 4) != 0;
      c   = (($urandom % 12) == 0) ? NC'($urandom) : '0;
      clr = m_halt ? (($urandom % 5) == 0) : (($urandom % 30) == 0);
      step(tv, c, clr, "R2/R4/R5/R7");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule